// File: doc/BRIEF.md
# Stochastic 10-bit PWM generator

This block sets the brightness of one LED channel. It takes a 10-bit duty value and drives a single output. Over every 1024-clock period the output is high for exactly as many clocks as the duty value. The high clocks are scattered pseudo-randomly across the period instead of sitting together at its start. Neighbouring channels with equal duty values therefore do not all switch on in the same clock, and this cuts the current surge on a shared supply.

The period is split into 64 segments of 16 clocks. Inside each segment, a 4-bit pseudo-random source visits every value 0..15 exactly once. Comparing that value against the upper duty field gives two candidate streams: a narrow one with sel high clocks and a wide one with sel+1 high clocks. A 6-bit source works the same way across the 64 segments. Comparing its value against the lower duty field decides, for each segment, which stream reaches the output.

Both sources advance one extra step per cycle of their window, so their starting points drift every segment and every period. This keeps the pattern from repeating. Each source can be seeded from the ports. The duty value is taken only at a period boundary, and the output leaves through a flip-flop.

Top module: `stoch_pwm`

## Requirements
- R1: While rstN is low, pwmOut is 0. The duty register clears to 0 in reset, so the first 1024-clock period after reset release has no high clocks.
- R2: Let sel be duty[9:6] and m be duty[5:0]. Periods are aligned to reset release: period k covers the outputs after clock edges 1024k+1 through 1024k+1024 following release, because the output is registered one clock late. Each period contains exactly 64*sel+m high clocks, provided no seed load fell inside it.
- R3: Inside a period, every 16-clock segment holds either sel or sel+1 high clocks. Exactly m segments hold sel+1. With sel=15 the wide segments are fully high.
- R4: duty is sampled only in the last clock of a period. A change during a period has no effect on that period's count.
- R5: Two consecutive periods with the same duty value, and no seed load, do not produce identical output patterns.
- R6: fineLoad (active high) loads fineSeed into the 4-bit source, and segLoad (active high) loads segSeed into the 6-bit source. With equal seeds loaded at the same point after reset, the output patterns are identical. With different seeds, the patterns differ.
- R7: A seed of all zeros is loaded as the value 1. The pattern then equals the pattern from seed 1, and neither source ever holds the all-zero state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one clock is one PWM time slot |
| rstN | input | 1 | Asynchronous reset, active low |
| duty | input | 10 | Duty value: [9:6] selects stream density, [5:0] counts wide segments |
| fineSeed | input | 4 | Seed for the per-clock source |
| fineLoad | input | 1 | Load strobe for fineSeed, active high |
| segSeed | input | 6 | Seed for the per-segment source |
| segLoad | input | 1 | Load strobe for segSeed, active high |
| pwmOut | output | 1 | Registered PWM drive, active high |

## Verification
The period boundary cannot be seen at the ports, yet the exact-count, boundary-sampling and non-repetition properties all depend on it. The bench releases reset on a falling clock edge and counts clocks from there, so it always knows which output samples form a period. To show that a mid-period duty change is ignored, it changes duty halfway through a counted period and expects the old count. Differences in the random order are shown by capturing whole 1024-bit output patterns and comparing them: across consecutive periods, and across resets with equal, different and zero seeds.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  // Strobes from the period sequencer to the datapath
  typedef struct packed {
    logic fineZero;   // first clock of a segment
    logic segZero;    // first segment of a period
    logic segStep;    // last clock of a segment
    logic periodEnd;  // last clock of a period
  } pwm_ctl_t;

  // Maximal-length feedback masks (Fibonacci, shift toward MSB)
  function automatic logic [7:0] tapMask(int w);
    case (w)
      3:       return 8'b0000_0110;
      4:       return 8'b0000_1100;
      5:       return 8'b0001_0100;
      6:       return 8'b0011_0000;
      7:       return 8'b0110_0000;
      default: return 8'b1011_1000;
    endcase
  endfunction

endpackage

// File: rtl/pwm_lfsr_src.sv
module pwm_lfsr_src #(
  parameter int W = 4,
  parameter logic [W-1:0] INIT = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         step,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         zeroSlot,
  output logic [W-1:0] value
);
  localparam logic [W-1:0] TAPS = W'(pwm_pkg::tapMask(W));
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] state;
  logic [W-1:0] nextState;
  logic [W-1:0] seedSafe;

  assign nextState = {state[W-2:0], ^(state & TAPS)};
  assign seedSafe  = (seed == '0) ? ONE : seed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     state <= INIT;
    else if (load) state <= seedSafe;
    else if (step) state <= nextState;
  end

  // One slot per window shows zero, so all 2^W values appear once
  assign value = zeroSlot ? '0 : state;

  a_r7_state_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    state != '0);

endmodule

// File: rtl/pwm_ctl.sv
module pwm_ctl #(
  parameter int FINE_W = 4,
  parameter int SEG_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  output pwm_pkg::pwm_ctl_t ctl
);
  localparam int DUTY_W = FINE_W + SEG_W;

  logic [DUTY_W-1:0] slotCnt;
  logic [FINE_W-1:0] phase;
  logic [SEG_W-1:0]  segIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) slotCnt <= '0;
    else       slotCnt <= slotCnt + 1'b1;
  end

  assign phase  = slotCnt[FINE_W-1:0];
  assign segIdx = slotCnt[DUTY_W-1:FINE_W];

  always_comb begin
    ctl.fineZero  = (phase == '0);
    ctl.segZero   = (segIdx == '0);
    ctl.segStep   = (phase == '1);
    ctl.periodEnd = (phase == '1) && (segIdx == '1);
  end

endmodule

// File: rtl/pwm_dp.sv
module pwm_dp #(
  parameter int FINE_W = 4,
  parameter int SEG_W  = 6,
  localparam int DUTY_W = FINE_W + SEG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwm_pkg::pwm_ctl_t ctl,
  input  logic [DUTY_W-1:0] duty,
  input  logic [FINE_W-1:0] fineSeed,
  input  logic              fineLoad,
  input  logic [SEG_W-1:0]  segSeed,
  input  logic              segLoad,
  output logic              pwmOut
);
  logic [DUTY_W-1:0] dutyReg;
  logic [FINE_W-1:0] fineVal;
  logic [SEG_W-1:0]  segVal;
  logic [FINE_W-1:0] selField;
  logic [SEG_W-1:0]  wideCnt;
  logic              narrowBit;
  logic              wideBit;
  logic              useWide;
  logic              streamBit;

  // Duty only changes at the period edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              dutyReg <= '0;
    else if (ctl.periodEnd) dutyReg <= duty;
  end

  pwm_lfsr_src #(.W(FINE_W)) uFine (
    .clk(clk), .rstN(rstN), .step(1'b1), .load(fineLoad), .seed(fineSeed),
    .zeroSlot(ctl.fineZero), .value(fineVal)
  );

  pwm_lfsr_src #(.W(SEG_W)) uSeg (
    .clk(clk), .rstN(rstN), .step(ctl.segStep), .load(segLoad), .seed(segSeed),
    .zeroSlot(ctl.segZero), .value(segVal)
  );

  assign selField  = dutyReg[DUTY_W-1:SEG_W];
  assign wideCnt   = dutyReg[SEG_W-1:0];
  assign narrowBit = {1'b0, fineVal} < {1'b0, selField};
  assign wideBit   = {1'b0, fineVal} < ({1'b0, selField} + 1'b1);
  assign useWide   = segVal < wideCnt;
  assign streamBit = useWide ? wideBit : narrowBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pwmOut <= 1'b0;
    else       pwmOut <= streamBit;
  end

  // ---- assertion support: per-period high count ----
  logic [DUTY_W:0] accum;
  logic            loadSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accum    <= '0;
      loadSeen <= 1'b0;
    end else begin
      accum    <= ctl.periodEnd ? '0 : accum + {{DUTY_W{1'b0}}, streamBit};
      loadSeen <= (fineLoad || segLoad) ? 1'b1 : (ctl.periodEnd ? 1'b0 : loadSeen);
    end
  end

  a_r1_reset_dark: assert property (@(posedge clk)
    !rstN |-> !pwmOut);

  a_r2_period_count: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.periodEnd && !loadSeen) |->
      (accum + {{DUTY_W{1'b0}}, streamBit}) == {1'b0, dutyReg});

  a_r3_stream_nested: assert property (@(posedge clk) disable iff (!rstN)
    narrowBit |-> wideBit);

  a_r4_duty_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.periodEnd |=> $stable(dutyReg));

endmodule

// File: rtl/stoch_pwm.sv
module stoch_pwm #(
  parameter int FINE_W = 4,
  parameter int SEG_W  = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [FINE_W+SEG_W-1:0]  duty,
  input  logic [FINE_W-1:0]        fineSeed,
  input  logic                     fineLoad,
  input  logic [SEG_W-1:0]         segSeed,
  input  logic                     segLoad,
  output logic                     pwmOut
);
  pwm_pkg::pwm_ctl_t ctl;

  pwm_ctl #(.FINE_W(FINE_W), .SEG_W(SEG_W)) uCtl (
    .clk(clk), .rstN(rstN), .ctl(ctl)
  );

  pwm_dp #(.FINE_W(FINE_W), .SEG_W(SEG_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .duty(duty),
    .fineSeed(fineSeed), .fineLoad(fineLoad),
    .segSeed(segSeed), .segLoad(segLoad), .pwmOut(pwmOut)
  );

endmodule

// File: tb/stoch_pwm_test.sv
`timescale 1ns/1ps
module stoch_pwm_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] duty = '0;
  logic [3:0] fineSeed = '0;
  logic       fineLoad = 1'b0;
  logic [5:0] segSeed = '0;
  logic       segLoad = 1'b0;
  logic       pwmOut;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  stoch_pwm uut (
    .clk(clk), .rstN(rstN), .duty(duty), .fineSeed(fineSeed),
    .fineLoad(fineLoad), .segSeed(segSeed), .segLoad(segLoad), .pwmOut(pwmOut)
  );

  // duty value and expected high count per period (64*sel + m)
  localparam int NV = 10;
  localparam int VDUTY [NV] = '{0, 96, 1023, 1, 63, 64, 960, 1008, 512, 37};
  localparam int VEXP  [NV] = '{0, 96, 1023, 1, 63, 64, 960, 1008, 512, 37};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic capture(output logic [1023:0] pat);
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      pat[i] = pwmOut;
    end
  endtask

  task automatic skipPeriod();
    repeat (1024) @(negedge clk);
  endtask

  function automatic int popCount(input logic [1023:0] pat);
    int c = 0;
    for (int i = 0; i < 1024; i++) c += pat[i];
    return c;
  endfunction

  task automatic checkSegments(input logic [1023:0] pat, input int d, input string tag);
    int sel = d / 64;
    int m = d % 64;
    int wide = 0;
    bit okSeg = 1'b1;
    for (int s = 0; s < 64; s++) begin
      int c = 0;
      for (int j = 0; j < 16; j++) c += pat[s*16+j];
      if (c == sel + 1) wide++;
      else if (c != sel) okSeg = 1'b0;
    end
    check(okSeg && wide == m, tag, wide, m);
  endtask

  // reset, load seeds one clock after release, return pattern of period 1
  task automatic seededRun(input logic [3:0] fs, input logic [5:0] ss,
                           output logic [1023:0] pat);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    fineSeed = fs; segSeed = ss; fineLoad = 1'b1; segLoad = 1'b1;
    @(negedge clk);
    fineLoad = 1'b0; segLoad = 1'b0;
    repeat (1023) @(negedge clk);
    capture(pat);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [1023:0] pa, pb, pc;
    int cnt;

    // R1: reset holds output low
    duty = 10'd500;
    repeat (5) @(negedge clk);
    check(pwmOut == 1'b0, "R1 output in reset", pwmOut, 0);
    rstN = 1'b1;
    capture(pa);
    check(popCount(pa) == 0, "R1 first period dark", popCount(pa), 0);
    capture(pa);
    check(popCount(pa) == 500, "R2 first lit period", popCount(pa), 500);

    // R2/R3: vector table
    for (int v = 0; v < NV; v++) begin
      duty = 10'(VDUTY[v]);
      skipPeriod();
      capture(pa);
      check(popCount(pa) == VEXP[v], $sformatf("R2 count duty=%0d", VDUTY[v]),
            popCount(pa), VEXP[v]);
      checkSegments(pa, VDUTY[v], $sformatf("R3 segments duty=%0d", VDUTY[v]));
    end

    // R4: mid-period change ignored
    duty = 10'd300;
    skipPeriod();
    cnt = 0;
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      cnt += pwmOut;
      if (i == 500) duty = 10'd900;
    end
    check(cnt == 300, "R4 mid-period change ignored", cnt, 300);
    capture(pa);
    check(popCount(pa) == 900, "R4 new duty next period", popCount(pa), 900);

    // R5: consecutive periods differ
    duty = 10'd300;
    skipPeriod();
    capture(pa);
    capture(pb);
    check(popCount(pa) == 300 && popCount(pb) == 300, "R5 counts", popCount(pb), 300);
    check(pa != pb, "R5 pattern repeats", popCount(pa ^ pb), 1);

    // R6: seed loads
    seededRun(4'd5, 6'd33, pa);
    seededRun(4'd5, 6'd33, pb);
    seededRun(4'd9, 6'd17, pc);
    check(popCount(pa) == 300, "R6 seeded count", popCount(pa), 300);
    check(pa == pb, "R6 equal seeds same pattern", popCount(pa ^ pb), 0);
    check(pa != pc, "R6 different seeds differ", popCount(pa ^ pc), 1);

    // R7: zero seed acts as one
    seededRun(4'd0, 6'd0, pa);
    seededRun(4'd1, 6'd1, pb);
    check(pa == pb, "R7 zero seed equals one", popCount(pa ^ pb), 0);
    check(popCount(pa) == 300, "R7 zero seed count", popCount(pa), 300);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule